// File: doc/BRIEF.md
# Programmable-Length Byte Delay Line

This block delays a byte stream by a number of clock cycles set by a 4-bit length code. Every edge of a single clock moves the data one stage along a fixed register chain. A multiplexer picks one tap of that chain, and the picked tap feeds a registered output. The default build splits the byte into two 4-bit lanes that share the clock and the controls. It adds 3 cycles to the code, so codes 0 to 15 give delays of 3 to 18 cycles.

A mode input chooses how the lanes behave. With the mode low, both nibbles take the programmed delay. With the mode high, the low nibble is held at the largest delay and the high nibble still follows the code. The length code and the mode are both registered. The chain never stops shifting, so changing the length moves the tap and does not flush the line. A longer length shows one sample twice; a shorter length drops samples. A build parameter selects a single 8-bit lane instead, with a delay of code + 1 and no split mode.

Top module: `tap_delay_line`

## Requirements
- R1: With split_mode low in the default build, a byte sampled on din at edge n appears whole on dout right after edge n + code + 2, so the total delay is code + 3 registers (3 for code 0, 18 for code 15).
- R2: With split_mode high in the default build, dout[3:0] carries din[3:0] from 18 registers earlier, whatever the length code.
- R3: With split_mode high in the default build, dout[7:4] still takes the programmed delay of code + 3 registers.
- R4: len_code and split_mode are captured on one rising edge, and the output tap they select first acts on the following edge. The code value used for dout after edge m is the one present at edge m - 1.
- R5: While data streams, raising the code by one makes exactly one sample appear on two consecutive cycles. Lowering the code by k skips k samples, so a counting stream jumps by k + 1 once.
- R6: Synchronous active-high reset drives dout to 0 on the edge where it is seen, clears every data stage, and sets the code to 0 and the mode to 0. After reset, dout reads 0 until real data reaches the tap.
- R7: Each data bit goes through unchanged and stays at its own bit position. No arithmetic and no reordering is applied.
- R8: With SPLIT_LANES = 0, one 8-bit lane has a delay of code + 1 registers: code 0 gives dout after edge n equal to din at edge n. split_mode has no effect in this build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W (8) | Data stream entering the delay line |
| len_code | input | CODE_W (4) | Length code; the delay grows by one per code step |
| split_mode | input | 1 | 1 pins the low nibble to the largest delay (split build only) |
| dout | output | DATA_W (8) | Delayed data, registered |

## Verification
A chain stage that fails to advance, or a tap selector that reads the wrong stage, shifts the output by whole cycles. The bench shows this as a mismatch against its own history model on the first sample that passes the faulty point, which is no more than 18 cycles after the data enters. A control register captured one edge too early or too late moves a length change by one cycle. The check at the repeated or skipped sample catches that in the cycle where the change lands. A wrong reset or mode state shows as non-zero bytes straight after reset, or as a low nibble that follows the code while the split mode is set.

// File: rtl/dl_pkg.sv
package dl_pkg;

  typedef enum logic {
    LANES_EVEN  = 1'b0,
    LANES_SPLIT = 1'b1
  } lane_mode_e;

endpackage

// File: rtl/dl_ctrl_reg.sv
module dl_ctrl_reg
  import dl_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter bit HAS_SPLIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  input  logic              mode_in,
  output logic [CODE_W-1:0] code_q,
  output lane_mode_e        mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mode_q <= LANES_EVEN;
    end else begin
      code_q <= code_in;
      if (HAS_SPLIT && mode_in) mode_q <= LANES_SPLIT;
      else                      mode_q <= LANES_EVEN;
    end
  end

  AST_CODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> code_q == $past(code_in)); // R4

  AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mode_q == LANES_SPLIT) == (HAS_SPLIT && $past(mode_in))); // R4

endmodule

// File: rtl/dl_lane.sv
module dl_lane #(
  parameter int W      = 4,
  parameter int SEL_W  = 4,
  parameter bit IN_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     dout
);

  localparam int DEPTH = 1 << SEL_W;
  localparam int CHAIN = IN_REG ? DEPTH : DEPTH - 1;

  logic [W-1:0] chain_q [CHAIN];
  logic [W-1:0] taps    [DEPTH];
  logic [W-1:0] head;
  logic [W-1:0] picked;

  generate
    if (IN_REG) begin : g_in_reg
      logic [W-1:0] in_q;
      always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= din;
      end
      assign head = in_q;
      for (genvar t = 0; t < DEPTH; t++) begin : g_tap
        assign taps[t] = chain_q[t];
      end
    end else begin : g_direct
      assign head    = din;
      assign taps[0] = din;
      for (genvar t = 1; t < DEPTH; t++) begin : g_tap
        assign taps[t] = chain_q[t-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CHAIN; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= head;
      for (int i = 1; i < CHAIN; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  generate
    for (genvar s = 1; s < CHAIN; s++) begin : g_chk
      AST_CHAIN_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> chain_q[s] == $past(chain_q[s-1])); // R1
    end
  endgenerate

  always_comb picked = taps[sel];

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= picked;
  end

  AST_OUT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dout == '0); // R6

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
  import dl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 4,
  parameter bit SPLIT_LANES = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [CODE_W-1:0] len_code,
  input  logic              split_mode,
  output logic [DATA_W-1:0] dout
);

  localparam int          HALF_W = DATA_W / 2;
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q;
  lane_mode_e        mode_q;

  dl_ctrl_reg #(
    .CODE_W    (CODE_W),
    .HAS_SPLIT (SPLIT_LANES)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .code_in (len_code),
    .mode_in (split_mode),
    .code_q  (code_q),
    .mode_q  (mode_q)
  );

  generate
    if (SPLIT_LANES) begin : g_split
      logic [CODE_W-1:0] lo_sel;
      logic [HALF_W-1:0] lo_out;
      logic [HALF_W-1:0] hi_out;

      always_comb lo_sel = (mode_q == LANES_SPLIT) ? MAX_CODE : code_q;

      dl_lane #(.W(HALF_W), .SEL_W(CODE_W), .IN_REG(1'b1)) i_lo (
        .clk  (clk),
        .rst  (rst),
        .din  (din[HALF_W-1:0]),
        .sel  (lo_sel),
        .dout (lo_out)
      );

      dl_lane #(.W(DATA_W-HALF_W), .SEL_W(CODE_W), .IN_REG(1'b1)) i_hi (
        .clk  (clk),
        .rst  (rst),
        .din  (din[DATA_W-1:HALF_W]),
        .sel  (code_q),
        .dout (hi_out)
      );

      assign dout = {hi_out, lo_out};
    end else begin : g_single
      dl_lane #(.W(DATA_W), .SEL_W(CODE_W), .IN_REG(1'b0)) i_all (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .sel  (code_q),
        .dout (dout)
      );
    end
  endgenerate

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_q == '0 && mode_q == LANES_EVEN && dout == '0)); // R6

endmodule

// File: tb/test_tap_delay_line.sv
`timescale 1ns/1ps
module test_tap_delay_line;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic [3:0] len_code = '0;
  logic       split_mode = 1'b0;
  logic [7:0] dout;
  logic [7:0] dout_single;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int rst_mark = -1000;
  bit done  = 1'b0;

  logic [7:0] hd [64];
  logic [3:0] hc [64];
  logic       hm [64];

  logic [7:0] prev_out = '0;
  bit         watch = 1'b0;
  int         rep_cnt = 0;
  int         jump_cnt = 0;
  int         jump_want = 0;

  always #4 clk = ~clk;

  tap_delay_line i_tap_delay_line (
    .clk(clk), .rst(rst), .din(din), .len_code(len_code),
    .split_mode(split_mode), .dout(dout));

  tap_delay_line #(.SPLIT_LANES(1'b0)) i_tap_delay_line_single (
    .clk(clk), .rst(rst), .din(din), .len_code(len_code),
    .split_mode(split_mode), .dout(dout_single));

  function automatic logic [7:0] hist_at(int k);
    if (k < 0 || k <= rst_mark) return 8'h00;
    return hd[k % 64];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual %02h expected %02h", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] d, input logic [3:0] c, input logic m);
    int cq;
    int lq;
    logic [7:0] e;
    din = d; len_code = c; split_mode = m;
    @(posedge clk);
    hd[cyc % 64] = rst ? 8'h00 : d;
    hc[cyc % 64] = rst ? 4'h0 : c;
    hm[cyc % 64] = rst ? 1'b0 : m;
    if (rst) rst_mark = cyc;
    @(negedge clk);
    if (rst) begin
      check("R6 split build cleared", dout, 8'h00);
      check("R6 single build cleared", dout_single, 8'h00);
    end else begin
      cq = int'(hc[(cyc-1) % 64]);
      lq = hm[(cyc-1) % 64] ? 15 : cq;
      e[7:4] = hist_at(cyc - 2 - cq) >> 4;
      e[3:0] = hist_at(cyc - 2 - lq) & 8'h0f;
      check("R1 R2 R3 R4 R7 split build", dout, e);
      check("R8 R4 single build", dout_single, hist_at(cyc - cq));
      if (watch) begin
        if (dout == prev_out) rep_cnt++;
        if (int'(dout) - int'(prev_out) == jump_want) jump_cnt++;
      end
    end
    prev_out = dout;
    cyc++;
  endtask

  initial begin
    logic [7:0] cnt;
    logic [3:0] code;
    logic       mode;
    void'($urandom(32'd1234));
    repeat (3) step(8'h00, 4'h0, 1'b0);
    rst = 1'b0;
    // R6: after reset the controls are code 0 / mode 0 and the output stays zero
    step(8'h11, 4'h0, 1'b0);
    check("R6 zero after reset", dout, 8'h00);
    // R1: code 0 minimum, code 15 maximum, distinct bit patterns (R7)
    for (int i = 0; i < 24; i++) step(8'h80 >> (i % 8) | 8'h01, 4'h0, 1'b0);
    for (int i = 0; i < 24; i++) step(8'hA5 ^ 8'(i), 4'hF, 1'b0);
    // R2/R3: split mode with a short code
    for (int i = 0; i < 30; i++) step(8'(i * 37), 4'h2, 1'b1);
    // R5: counting stream, raise the code by one then lower it by three
    cnt = 8'd20;
    for (int i = 0; i < 25; i++) begin step(cnt, 4'h5, 1'b0); cnt++; end
    watch = 1'b1; rep_cnt = 0; jump_cnt = 0; jump_want = 99;
    for (int i = 0; i < 6; i++) begin step(cnt, 4'h6, 1'b0); cnt++; end
    watch = 1'b0;
    check("R5 one repeat on longer code", 8'(rep_cnt), 8'd1);
    for (int i = 0; i < 10; i++) begin step(cnt, 4'h6, 1'b0); cnt++; end
    watch = 1'b1; rep_cnt = 0; jump_cnt = 0; jump_want = 4;
    for (int i = 0; i < 6; i++) begin step(cnt, 4'h3, 1'b0); cnt++; end
    watch = 1'b0;
    check("R5 one skip of three samples on shorter code", 8'(jump_cnt), 8'd1);
    check("R5 no repeat on shorter code", 8'(rep_cnt), 8'd0);
    // mid-run reset (R6)
    rst = 1'b1;
    step(8'hFF, 4'h9, 1'b1);
    step(8'hFF, 4'h9, 1'b1);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) step(8'hC3, 4'h7, 1'b0);
    // random stream with code and mode changes (R8: mode ignored in single build)
    code = 4'h4; mode = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(7) == 0) code = 4'($urandom_range(15));
      if ($urandom_range(15) == 0) mode = ~mode;
      step(8'($urandom), code, mode);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule